// File: doc/BRIEF.md
# Receive System Interface Formatter

This block presents one receive channel to the system side on three pins. A 2-bit format field chooses the meaning of those pins. In single-rail NRZ, the pins carry decoded data, a steerable indication and the recovered clock. In dual-rail NRZ and dual-rail RZ, they carry undecoded positive and negative rails and the recovered clock. In dual-rail sliced, they carry the raw slicer rails and the indication.

The recovered line clock arrives as an ordinary input. It is sampled by the fast system clock `clk`, and the block updates its outputs on the line-clock edge that the edge-select bit picks. The multifunction (indication) output can be steered to one of several status sources, to the recovered clock, or to the XOR of the sliced rails. That output is always active high. The data and rail outputs follow an invert bit.

Top module: `rx_sys_fmt`

## Requirements
- R1: `fmt` codes are 0 single-rail NRZ, 1 dual-rail NRZ, 2 dual-rail RZ and 3 dual-rail sliced. A new code is taken only on an active line-clock edge, so the pin meaning never changes between active edges.
- R2: In format 0, `pin_a` is `dec_data` and `pin_b` is the indication, both captured on the active edge. `pin_c` is `rec_clk` delayed by one `clk` cycle.
- R3: In format 1, `pin_a` and `pin_b` are `rail_p` and `rail_n` captured on the active edge, and `pin_c` is the delayed `rec_clk`.
- R4: In format 2, the captured rails appear only from an active edge until the next opposite line-clock edge. Outside that first half, both rail pins sit at their inactive level. `pin_c` is the delayed `rec_clk`.
- R5: In format 3, `pin_a` and `pin_b` are `slc_p` and `slc_n` sampled on every `clk` cycle, and `pin_c` is the indication sampled on every `clk` cycle.
- R6: `ind_sel` picks the indication source: 0 pattern detect, 1 AIS, 2 excess zeros, 3 bipolar violation, 4 excess zeros OR bipolar violation, 5 loss of signal, 6 recovered clock, 7 `slc_p` XOR `slc_n`.
- R7: When `inv`=1, the data and rail values on `pin_a` and `pin_b` are inverted. The indication is never inverted.
- R8: When `edge_neg`=0, the active edge is the rising edge of `rec_clk`. When `edge_neg`=1, it is the falling edge. An edge is seen in the `clk` cycle where `rec_clk` differs from its previous sample.
- R9: While `rst_n` is low, all internal state is 0, so with `inv`=0 all three pins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Output format select |
| ind_sel | input | 3 | Indication source select |
| inv | input | 1 | Invert data and rail outputs |
| edge_neg | input | 1 | Select falling line-clock edge as active |
| rec_clk | input | 1 | Recovered line clock |
| dec_data | input | 1 | Decoded single-rail data |
| rail_p | input | 1 | Undecoded positive rail |
| rail_n | input | 1 | Undecoded negative rail |
| slc_p | input | 1 | Raw sliced positive rail |
| slc_n | input | 1 | Raw sliced negative rail |
| ind_prbs | input | 1 | Pattern detect indication |
| ind_ais | input | 1 | AIS indication |
| ind_exz | input | 1 | Excess zeros indication |
| ind_bpv | input | 1 | Bipolar violation indication |
| ind_los | input | 1 | Loss of signal indication |
| pin_a | output | 1 | Data or positive rail |
| pin_b | output | 1 | Negative rail or indication |
| pin_c | output | 1 | Recovered clock or indication |

## Verification
The hardest case to reach is a format change that arrives between active edges. The pins must keep their old meaning until the next active edge, and in RZ the half-bit gate must line up with the edge polarity in force at that moment. To reach it, the stimulus changes `fmt`, `inv`, `edge_neg` and `ind_sel` at arbitrary `clk` cycles while `rec_clk` runs at one eighth of the system rate. Every data and indication input is randomised on every cycle, and a behavioural model is compared against all three pins on every cycle.

// File: rtl/rx_sys_fmt.sv
module rx_sys_fmt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt,
  input  logic [2:0] ind_sel,
  input  logic       inv,
  input  logic       edge_neg,
  input  logic       rec_clk,
  input  logic       dec_data,
  input  logic       rail_p,
  input  logic       rail_n,
  input  logic       slc_p,
  input  logic       slc_n,
  input  logic       ind_prbs,
  input  logic       ind_ais,
  input  logic       ind_exz,
  input  logic       ind_bpv,
  input  logic       ind_los,
  output logic       pin_a,
  output logic       pin_b,
  output logic       pin_c
);

  localparam logic [1:0] F_SNRZ = 2'd0;
  localparam logic [1:0] F_DNRZ = 2'd1;
  localparam logic [1:0] F_DRZ  = 2'd2;
  localparam logic [1:0] F_SLC  = 2'd3;

  logic       rclk_q, half_q;
  logic [1:0] fmt_q;
  logic       d_q, p_q, n_q, sp_q, sn_q, ind_q, ind_e_q;
  logic       ind_now;

  wire chg      = rec_clk ^ rclk_q;
  wire act_edge = chg & (rec_clk ^ edge_neg);
  wire opp_edge = chg & ~act_edge;

  always_comb begin
    case (ind_sel)
      3'd0:    ind_now = ind_prbs;
      3'd1:    ind_now = ind_ais;
      3'd2:    ind_now = ind_exz;
      3'd3:    ind_now = ind_bpv;
      3'd4:    ind_now = ind_exz | ind_bpv;
      3'd5:    ind_now = ind_los;
      3'd6:    ind_now = rec_clk;
      default: ind_now = slc_p ^ slc_n;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rclk_q  <= 1'b0;
      half_q  <= 1'b0;
      fmt_q   <= F_SNRZ;
      d_q     <= 1'b0;
      p_q     <= 1'b0;
      n_q     <= 1'b0;
      sp_q    <= 1'b0;
      sn_q    <= 1'b0;
      ind_q   <= 1'b0;
      ind_e_q <= 1'b0;
    end else begin
      rclk_q <= rec_clk;
      sp_q   <= slc_p;
      sn_q   <= slc_n;
      ind_q  <= ind_now;
      if (act_edge) begin
        fmt_q   <= fmt;
        d_q     <= dec_data;
        p_q     <= rail_p;
        n_q     <= rail_n;
        ind_e_q <= ind_now;
        half_q  <= 1'b1;
      end else if (opp_edge) begin
        half_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (fmt_q)
      F_SNRZ: begin
        pin_a = d_q ^ inv;
        pin_b = ind_e_q;
        pin_c = rclk_q;
      end
      F_DNRZ: begin
        pin_a = p_q ^ inv;
        pin_b = n_q ^ inv;
        pin_c = rclk_q;
      end
      F_DRZ: begin
        pin_a = (p_q & half_q) ^ inv;
        pin_b = (n_q & half_q) ^ inv;
        pin_c = rclk_q;
      end
      default: begin
        pin_a = sp_q ^ inv;
        pin_b = sn_q ^ inv;
        pin_c = ind_q;
      end
    endcase
  end

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_edge |=> $stable(fmt_q)); // R1

  AST_CLK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q != F_SLC && $past(rst_n)) |-> pin_c == $past(rec_clk)); // R2

  AST_RZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_DRZ && !half_q) |-> (pin_a == inv && pin_b == inv)); // R4

  AST_SLC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == F_SLC && $past(rst_n)) |-> ((pin_a ^ inv) == $past(slc_p) && (pin_b ^ inv) == $past(slc_n))); // R5

  AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    opp_edge |=> !half_q); // R8

endmodule

// File: tb/tb_rx_sys_fmt.sv
module tb_rx_sys_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [2:0] ind_sel = 3'd0;
  logic inv = 1'b0, edge_neg = 1'b0, rec_clk = 1'b0;
  logic dec_data = 0, rail_p = 0, rail_n = 0, slc_p = 0, slc_n = 0;
  logic ind_prbs = 0, ind_ais = 0, ind_exz = 0, ind_bpv = 0, ind_los = 0;
  logic pin_a, pin_b, pin_c;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  rx_sys_fmt dut (.*);

  // behavioural reference state
  int m_rc, m_half, m_fmt, m_d, m_p, m_n, m_sp, m_sn, m_ind, m_inde;

  function automatic int pick_ind();
    case (ind_sel)
      0: return ind_prbs;
      1: return ind_ais;
      2: return ind_exz;
      3: return ind_bpv;
      4: return (ind_exz || ind_bpv) ? 1 : 0;
      5: return ind_los;
      6: return rec_clk;
      default: return (slc_p != slc_n) ? 1 : 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int now_ind;
    bit rising, falling, active;
    if (!rst_n) begin
      m_rc = 0; m_half = 0; m_fmt = 0; m_d = 0; m_p = 0; m_n = 0;
      m_sp = 0; m_sn = 0; m_ind = 0; m_inde = 0;
    end else begin
      now_ind = pick_ind();
      rising  = (m_rc == 0) && rec_clk;
      falling = (m_rc == 1) && !rec_clk;
      active  = edge_neg ? falling : rising;        // R8
      if (active) begin                             // R1
        m_fmt = fmt; m_d = dec_data; m_p = rail_p; m_n = rail_n;
        m_inde = now_ind; m_half = 1;
      end else if (rising || falling) m_half = 0;   // R4
      m_sp = slc_p; m_sn = slc_n; m_ind = now_ind;  // R5 R6
      m_rc = rec_clk;
    end
  end

  task automatic compare(input string tag);
    int ea, eb, ec;
    case (m_fmt)
      0: begin ea = m_d ^ inv; eb = m_inde; ec = m_rc; end
      1: begin ea = m_p ^ inv; eb = m_n ^ inv; ec = m_rc; end
      2: begin ea = (m_p & m_half) ^ inv; eb = (m_n & m_half) ^ inv; ec = m_rc; end
      default: begin ea = m_sp ^ inv; eb = m_sn ^ inv; ec = m_ind; end
    endcase
    tests++;
    if (pin_a !== ea[0] || pin_b !== eb[0] || pin_c !== ec[0]) begin
      fails++;
      $display("FAIL %s (R7 inv=%0d R6 sel=%0d) pins=%b%b%b exp=%0d%0d%0d",
               tag, inv, ind_sel, pin_a, pin_b, pin_c, ea, eb, ec);
    end
  endtask

  function automatic string fmt_tag(int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  int phase = 0;

  initial begin
    repeat (3) @(negedge clk);
    tests++; // R9 reset state
    if (pin_a !== 1'b0 || pin_b !== 1'b0 || pin_c !== 1'b0) begin
      fails++;
      $display("FAIL R9 pins=%b%b%b exp=000", pin_a, pin_b, pin_c);
    end
    rst_n = 1'b1;
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 2; e++)
        for (int iv = 0; iv < 2; iv++)
          for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 40; c++) begin
              @(negedge clk);
              compare(fmt_tag(m_fmt));
              if (c == 3 + s) begin        // R1 R8 mid-bit config change
                fmt = f[1:0]; edge_neg = e[0]; inv = iv[0]; ind_sel = s[2:0];
              end
              phase = (phase + 1) % 8;
              rec_clk = (phase < 4);
              dec_data = $urandom; rail_p = $urandom; rail_n = $urandom;
              slc_p = $urandom; slc_n = $urandom;
              ind_prbs = $urandom; ind_ais = $urandom; ind_exz = $urandom;
              ind_bpv = $urandom; ind_los = $urandom;
            end
          end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule